// File: doc/BRIEF.md
# Banked Work RAM Controller

This block sits between a CPU's byte bus and a 32 KiB synchronous work RAM. It converts each bus address into a 15-bit physical RAM address. The lower 4 KiB of the work RAM window always shows physical bank 0. The upper 4 KiB window shows whichever bank a one-byte select register holds. Addresses in the mirror range are folded back onto the work RAM window before any other decoding. The select register itself sits at a fixed address on the same bus.

A legacy-mode input turns the block into a plain 8 KiB RAM. In that mode the upper window is fixed on physical bank 1, the select register reads as all ones, and writes to it are dropped. The register keeps its contents while legacy mode is active. When the block returns to colour mode, it uses the bank that was selected before.

Every read, whether of RAM or of the select register, returns its data one clock later. A one-cycle valid strobe marks the returned data. The RAM itself sits outside the block and is reached through a simple enable, write-enable, address and data port.

Top module: `wram_bank_ctrl`

## Requirements
- R1: After reset the selected bank is 1, `rd_valid` is low, and a colour-mode read of 0xFF70 returns 0xF9.
- R2: A request to 0xC000–0xCFFF asserts `ram_en` with `ram_addr` = addr − 0xC000, whatever bank is selected.
- R3: In colour mode, a request to 0xD000–0xDFFF asserts `ram_en` with `ram_addr` = bank × 4096 + (addr − 0xD000).
- R4: An address in 0xE000–0xFDFF is first replaced by 0xC000 + ((addr − 0xE000) & 0x1FFF) and is then decoded like R2 or R3.
- R5: A colour-mode write to 0xFF70 stores data bits [2:0] as the bank, and a stored value of 0 becomes 1. A colour-mode read of 0xFF70 returns bits [7:3] all ones and the bank in bits [2:0].
- R6: In legacy mode, a read of 0xFF70 returns 0xFF. A write to 0xFF70 leaves the bank unchanged, and this is visible after a return to colour mode.
- R7: In legacy mode, 0xD000–0xDFFF maps to `ram_addr` = 0x1000 + (addr − 0xD000), so every legacy RAM address is below 0x2000.
- R8: A read to a decoded address (work RAM, mirror, or 0xFF70) raises `rd_valid` for exactly the following cycle, with the data on `rd_data`. Writes never raise `rd_valid`.
- R9: A request to any other address leaves `ram_en` low and raises no `rd_valid`.
- R10: A write to work RAM or the mirror asserts `ram_en` and `ram_we`, and drives `ram_wdata` = `req_wdata`. A write to 0xFF70 does not touch the RAM port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | 1 = plain 8 KiB RAM behaviour |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Bus byte address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after the read) |
| rd_data | output | 8 | Read data |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 15 | Physical RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after `ram_en` |

## Verification
The hardest case to reach is a write to the select register during legacy mode. Its only effect would be on state that legacy mode hides. The bench first selects bank 5, then writes a different value to 0xFF70 in legacy mode, and then reads the register back in colour mode. A mirror access to the upper range (0xF000–0xFDFF) is run after the bank has changed, so that folding and banking are checked together. A reset in the middle of a run is applied after a bank other than 1 has been chosen.

// File: rtl/wram_pkg.sv
package wram_pkg;
  typedef enum logic [1:0] {
    RG_NONE   = 2'd0,
    RG_FIXED  = 2'd1,
    RG_BANKED = 2'd2,
    RG_SELREG = 2'd3
  } region_e;
endpackage

// File: rtl/wram_addr_decode.sv
module wram_addr_decode
  import wram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 12,
  parameter logic [ADDR_W-1:0] WRAM_BASE   = 16'hC000,
  parameter logic [ADDR_W-1:0] MIRROR_BASE = 16'hE000,
  parameter logic [ADDR_W-1:0] MIRROR_LAST = 16'hFDFF,
  parameter logic [ADDR_W-1:0] SEL_ADDR    = 16'hFF70
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [OFS_W-1:0]  ofs
);
  // two 4 KiB windows make up the work RAM span
  localparam logic [ADDR_W-1:0] SPAN      = ADDR_W'(2) << OFS_W;
  localparam logic [ADDR_W-1:0] FOLD_MASK = SPAN - ADDR_W'(1);

  logic              in_mirror;
  logic [ADDR_W-1:0] folded;
  logic [ADDR_W-1:0] rel;

  always_comb begin
    in_mirror = (addr >= MIRROR_BASE) && (addr <= MIRROR_LAST);
    folded    = in_mirror ? (WRAM_BASE | (addr & FOLD_MASK)) : addr;
    rel       = folded - WRAM_BASE;
    ofs       = rel[OFS_W-1:0];
    if (addr == SEL_ADDR)
      region = RG_SELREG;
    else if ((folded >= WRAM_BASE) && (rel < SPAN))
      region = rel[OFS_W] ? RG_BANKED : RG_FIXED;
    else
      region = RG_NONE;
  end
endmodule

// File: rtl/wram_bank_sel.sv
module wram_bank_sel #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              legacy,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  output logic [BANK_W-1:0] bank_q,
  output logic [DATA_W-1:0] rd_value
);
  localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

  always_ff @(posedge clk) begin
    if (rst)
      bank_q <= BANK_ONE;
    else if (wr_en && !legacy)
      bank_q <= (wr_bank == '0) ? BANK_ONE : wr_bank;
  end

  always_comb begin
    if (legacy)
      rd_value = '1;
    else
      rd_value = {{(DATA_W-BANK_W){1'b1}}, bank_q};
  end

  // R6: a legacy-mode write leaves the stored bank alone
  assert_legacy_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && legacy) |=> $stable(bank_q));
endmodule

// File: rtl/wram_rd_return.sv
module wram_rd_return #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              from_reg,
  input  logic [DATA_W-1:0] reg_value,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic              sel_reg_q;
  logic [DATA_W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      sel_reg_q <= 1'b0;
      reg_q     <= '0;
    end else begin
      rd_valid  <= rd_req;
      sel_reg_q <= from_reg;
      reg_q     <= reg_value;
    end
  end

  assign rd_data = sel_reg_q ? reg_q : ram_rdata;

  // R8: valid never appears without a read one cycle earlier
  assert_valid_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req));
endmodule

// File: rtl/wram_bank_ctrl.sv
module wram_bank_ctrl
  import wram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int OFS_W  = 12,
  parameter int BANK_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      legacy_mode,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      rd_valid,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      ram_en,
  output logic                      ram_we,
  output logic [BANK_W+OFS_W-1:0]   ram_addr,
  output logic [DATA_W-1:0]         ram_wdata,
  input  logic [DATA_W-1:0]         ram_rdata
);
  localparam int PHYS_W = BANK_W + OFS_W;
  localparam logic [PHYS_W-1:0] LEGACY_LIMIT = PHYS_W'(2) << OFS_W;

  region_e           region;
  logic [OFS_W-1:0]  ofs;
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] bank_eff;
  logic [DATA_W-1:0] sel_value;
  logic              is_ram;
  logic              sel_wr;
  logic              rd_req;

  wram_addr_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dec (
    .addr   (req_addr),
    .region (region),
    .ofs    (ofs)
  );

  assign sel_wr = req_valid && req_write && (region == RG_SELREG);

  wram_bank_sel #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .legacy   (legacy_mode),
    .wr_en    (sel_wr),
    .wr_bank  (req_wdata[BANK_W-1:0]),
    .bank_q   (bank_q),
    .rd_value (sel_value)
  );

  always_comb begin
    bank_eff  = legacy_mode ? BANK_W'(1) : bank_q;
    is_ram    = (region == RG_FIXED) || (region == RG_BANKED);
    ram_en    = req_valid && is_ram;
    ram_we    = ram_en && req_write;
    ram_wdata = req_wdata;
    ram_addr  = (region == RG_FIXED) ? {BANK_W'(0), ofs} : {bank_eff, ofs};
    rd_req    = req_valid && !req_write && (region != RG_NONE);
  end

  wram_rd_return #(.DATA_W(DATA_W)) u_ret (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .from_reg  (region == RG_SELREG),
    .reg_value (sel_value),
    .ram_rdata (ram_rdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  // R2: the fixed window never carries bank bits
  assert_fixed_window_R2: assert property (@(posedge clk) disable iff (rst)
    (ram_en && region == RG_FIXED) |-> (ram_addr[PHYS_W-1:OFS_W] == '0));

  // R7: legacy accesses stay inside the low 8 KiB
  assert_legacy_span_R7: assert property (@(posedge clk) disable iff (rst)
    (legacy_mode && ram_en) |-> (ram_addr < LEGACY_LIMIT));

  // R10: a RAM write always comes with an enable
  assert_we_with_en_R10: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_en);

  // R9: undecoded addresses leave the RAM port idle
  assert_outside_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && region == RG_NONE) |-> !ram_en);

  // R8: every decoded read returns one cycle later
  assert_read_returns_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && region != RG_NONE) |=> rd_valid);

  // R5: colour-mode register read pads upper bits with ones
  assert_sel_pad_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && region == RG_SELREG && !legacy_mode)
      |=> (rd_data[DATA_W-1:BANK_W] == '1));
endmodule

// File: tb/sim_wram_bank_ctrl.sv
module sim_wram_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        legacy_mode;
  logic        req_valid;
  logic        req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        ram_en;
  logic        ram_we;
  logic [14:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  wram_bank_ctrl u0 (
    .clk(clk), .rst(rst), .legacy_mode(legacy_mode),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // RAM stand-in: returns a pattern derived from the physical address
  function automatic logic [7:0] pattern(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]};
  endfunction

  always_ff @(posedge clk) begin
    if (ram_en && !ram_we) ram_rdata <= pattern(ram_addr);
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // fields: legacy, write, addr, wdata, exp ram_en, exp ram_addr, exp rd_valid, exp reg data
  localparam int NV = 23;
  localparam logic [50:0] VEC [NV] = '{
    {1'b0,1'b0,16'hC000,8'h00,1'b1,15'h0000,1'b1,8'h00}, // R2
    {1'b0,1'b0,16'hCFFF,8'h00,1'b1,15'h0FFF,1'b1,8'h00}, // R2
    {1'b0,1'b0,16'hD123,8'h00,1'b1,15'h1123,1'b1,8'h00}, // R3 bank 1
    {1'b0,1'b1,16'hFF70,8'h03,1'b0,15'h0000,1'b0,8'h00}, // R5 select 3
    {1'b0,1'b0,16'hFF70,8'h00,1'b0,15'h0000,1'b1,8'hFB}, // R5
    {1'b0,1'b0,16'hD123,8'h00,1'b1,15'h3123,1'b1,8'h00}, // R3 bank 3
    {1'b0,1'b0,16'hC456,8'h00,1'b1,15'h0456,1'b1,8'h00}, // R2 bank ignored
    {1'b0,1'b1,16'hDFFF,8'hA5,1'b1,15'h3FFF,1'b0,8'h00}, // R10
    {1'b0,1'b0,16'hE010,8'h00,1'b1,15'h0010,1'b1,8'h00}, // R4
    {1'b0,1'b0,16'hF456,8'h00,1'b1,15'h3456,1'b1,8'h00}, // R4 into banked
    {1'b0,1'b0,16'hFDFF,8'h00,1'b1,15'h3DFF,1'b1,8'h00}, // R4 top
    {1'b0,1'b1,16'hFF70,8'h00,1'b0,15'h0000,1'b0,8'h00}, // R5 zero -> 1
    {1'b0,1'b0,16'hFF70,8'h00,1'b0,15'h0000,1'b1,8'hF9}, // R5
    {1'b0,1'b1,16'hFF70,8'h0D,1'b0,15'h0000,1'b0,8'h00}, // R5 low bits -> 5
    {1'b0,1'b0,16'hD000,8'h00,1'b1,15'h5000,1'b1,8'h00}, // R3 bank 5
    {1'b0,1'b0,16'hFE00,8'h00,1'b0,15'h0000,1'b0,8'h00}, // R9
    {1'b0,1'b1,16'hBFFF,8'h11,1'b0,15'h0000,1'b0,8'h00}, // R9
    {1'b1,1'b0,16'hFF70,8'h00,1'b0,15'h0000,1'b1,8'hFF}, // R6
    {1'b1,1'b1,16'hFF70,8'h02,1'b0,15'h0000,1'b0,8'h00}, // R6 ignored
    {1'b1,1'b0,16'hD800,8'h00,1'b1,15'h1800,1'b1,8'h00}, // R7
    {1'b1,1'b0,16'hF800,8'h00,1'b1,15'h1800,1'b1,8'h00}, // R7 via mirror
    {1'b0,1'b0,16'hFF70,8'h00,1'b0,15'h0000,1'b1,8'hFD}, // R6 bank still 5
    {1'b0,1'b0,16'hD001,8'h00,1'b1,15'h5001,1'b1,8'h00}  // R3
  };

  task automatic drive(input logic lg, input logic we, input logic [15:0] a, input logic [7:0] wd);
    @(posedge clk); #1;
    legacy_mode = lg; req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = wd;
  endtask

  task automatic idle;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; legacy_mode = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 rd_valid after reset", rd_valid, 0);
    drive(1'b0, 1'b0, 16'hFF70, 8'h00);
    idle();
    @(negedge clk);
    check("R1 bank after reset", rd_data, 8'hF9);

    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      logic [7:0] exp_rd;
      v = VEC[i];
      drive(v[50], v[49], v[48:33], v[32:25]);
      @(negedge clk);
      check("R2 R3 R4 R7 R9 ram_en", ram_en, v[24]);
      if (v[24]) begin
        check("R2 R3 R4 R7 ram_addr", ram_addr, v[23:9]);
        check("R10 ram_we", ram_we, v[49]);
        if (v[49]) check("R10 ram_wdata", ram_wdata, v[32:25]);
      end
      idle();
      @(negedge clk);
      check("R8 R9 rd_valid", rd_valid, v[8]);
      if (v[8]) begin
        exp_rd = v[24] ? pattern(v[23:9]) : v[7:0];
        check("R5 R6 R8 rd_data", rd_data, exp_rd);
      end
    end

    // R8: valid lasts one cycle only
    drive(1'b0, 1'b0, 16'hC001, 8'h00);
    idle();
    @(negedge clk);
    check("R8 valid pulse", rd_valid, 1);
    @(posedge clk); @(negedge clk);
    check("R8 valid drops", rd_valid, 0);

    // R1: reset mid-run returns bank to 1 (bank is 5 here)
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    drive(1'b0, 1'b0, 16'hFF70, 8'h00);
    idle();
    @(negedge clk);
    check("R1 bank after mid-run reset", rd_data, 8'hF9);
    drive(1'b0, 1'b0, 16'hDABC, 8'h00);
    @(negedge clk);
    check("R1 R3 bank 1 mapping", ram_addr, 15'h1ABC);
    idle();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule